// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block produces the bit-rate timing for one channel of a serial controller. The block's clock serves as the reference, and its effective rate is half the clock rate. A 16-bit time constant divides this reference, with two added to the constant to give the ratio. The time constant comes from two byte-wide registers: one holds the upper eight bits and the other holds the lower eight bits. The divided signal is `rateClk`, a square wave whose level changes once every time-constant-plus-two clocks. A clock-mode field then divides its rising edges by 1, 16, 32 or 64, and `tick` pulses once for each completed prescale period. The frequency of the input clock is set by the system that uses the block. Typical values are 4.9152 MHz and 3.6864 MHz, and one common configuration limits the rate to 38400 baud.

All configuration goes through one byte-wide write port. A write to any of the four register slots restarts the generator from a known phase. These slots are the two time-constant bytes, the transmit control register and the receive control register. The generator therefore applies a new rate on a predictable edge and never carries over a partly finished count. When `brgEnable` is low, the generator is held in that restart state.

Top module: `baud_gen`

## Requirements
- R1: After reset, `tick` and `rateClk` are low, the time constant is 0 and the clock mode is x1, so the first `rateClk` rise comes on the 2nd rising clock edge after reset release, and `tick` then repeats every 4 clocks.
- R2: The time constant TC is {high byte, low byte}. `rateClk` holds each level for exactly TC+2 clocks, so it runs at (clock/2)/(TC+2). The minimum hold time is 2 clocks.
- R3: Bits [7:6] of the transmit control register select the clock mode: 0 selects x1, 1 selects x16, 2 selects x32 and 3 selects x64. Bits [5:0] of that register have no effect. `tick` repeats every 2*(TC+2)*M clocks, where M is the selected divisor.
- R4: `tick` is high for exactly one clock. It is high only in the cycle in which `rateClk` has just risen and that rise completes the prescale count.
- R5: Take a write captured on clock edge k. On edge k+1 the generator restarts: `rateClk` goes low, the prescale count clears and the counter reloads. `rateClk` first rises after edge k+1+(TC+2), and `tick` first pulses after edge k+1+(TC+2)+(M-1)*2*(TC+2).
- R6: While `brgEnable` is low, `tick` and `rateClk` stay low and the generator stays in its restart state. After the first edge with `brgEnable` high, `rateClk` rises after TC+2 edges and `tick` pulses after (TC+2)+(M-1)*2*(TC+2) edges.
- R7: `wrSel` chooses the register slot: 0 is the low time-constant byte, 1 is the high byte, 2 is transmit control and 3 is receive control. A write to slot 3 only restarts the generator (R5) and leaves the rate unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| brgEnable | input | 1 | Run enable; low holds the generator in restart |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register slot of the write |
| wrData | input | 8 | Write data |
| rateClk | output | 1 | Divided square wave, (clock/2)/(TC+2) |
| tick | output | 1 | One-clock pulse per prescale period |

## Verification
The hardest case to reach from the ports is a restart that lands partway through a count. In that case the phase that applies after the write must not depend on the phase before it. The stimulus writes each new configuration while the previous one is still running. It also writes the receive control slot at an arbitrary point in a count. For each case it measures the edge on which `rateClk` first rises, the edge on which `tick` first pulses, and the interval between ticks, all counted from the capture edge. The high-byte vector and the x64 vector show that all 16 bits of the time constant and the widest prescale take effect.

// File: rtl/brg_pkg.sv
package brg_pkg;

  localparam int BRG_BYTE_W = 8;
  localparam int BRG_PRE_W  = 6;   // wide enough for the x64 prescale
  localparam int BRG_MODE_LSB = 6; // clock-mode field position in transmit control

  localparam logic [1:0] SEL_TC_LO = 2'd0;
  localparam logic [1:0] SEL_TC_HI = 2'd1;
  localparam logic [1:0] SEL_TXCTL = 2'd2;
  localparam logic [1:0] SEL_RXCTL = 2'd3;

  typedef enum logic [1:0] {
    MODE_X1  = 2'd0,
    MODE_X16 = 2'd1,
    MODE_X32 = 2'd2,
    MODE_X64 = 2'd3
  } clkMode_e;

  typedef struct packed {
    logic wrLo;
    logic wrHi;
    logic wrMode;
    logic load;
  } brgStrb_t;

  // last prescale count before a tick, per clock mode
  function automatic logic [BRG_PRE_W-1:0] preLimit(clkMode_e m);
    case (m)
      MODE_X16: preLimit = BRG_PRE_W'(15);
      MODE_X32: preLimit = BRG_PRE_W'(31);
      MODE_X64: preLimit = BRG_PRE_W'(63);
      default:  preLimit = '0;
    endcase
  endfunction

endpackage

// File: rtl/brg_ctrl.sv
module brg_ctrl
  import brg_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     brgEnable,
  input  logic     wrEn,
  input  logic [1:0] wrSel,
  output brgStrb_t strb
);

  logic pendQ;

  // any register write schedules a restart on the following edge
  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= wrEn;
  end

  always_comb begin
    strb.wrLo   = wrEn && (wrSel == SEL_TC_LO);
    strb.wrHi   = wrEn && (wrSel == SEL_TC_HI);
    strb.wrMode = wrEn && (wrSel == SEL_TXCTL);
    strb.load   = pendQ || !brgEnable;
  end

endmodule

// File: rtl/brg_datapath.sv
module brg_datapath
  import brg_pkg::*;
#(
  parameter int BYTE_W   = BRG_BYTE_W,
  parameter int PRE_W    = BRG_PRE_W,
  parameter int MODE_LSB = BRG_MODE_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  brgStrb_t          strb,
  input  logic [BYTE_W-1:0] wrData,
  output logic              rateClk,
  output logic              tick
);

  localparam int TC_W  = 2 * BYTE_W;
  localparam int CNT_W = TC_W + 1;   // TC+1 must not wrap

  logic [BYTE_W-1:0] tcLo, tcHi;
  clkMode_e          modeQ;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  reloadVal;
  logic [PRE_W-1:0]  pre;
  logic              rateQ, tickQ;

  assign reloadVal = {1'b0, tcHi, tcLo} + CNT_W'(1);

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tcLo  <= '0;
      tcHi  <= '0;
      modeQ <= MODE_X1;
    end else begin
      if (strb.wrLo)   tcLo  <= wrData;
      if (strb.wrHi)   tcHi  <= wrData;
      if (strb.wrMode) modeQ <= clkMode_e'(wrData[MODE_LSB +: 2]);
    end
  end

  // divide counter, rate toggle and prescale
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= CNT_W'(1);
      rateQ <= 1'b0;
      pre   <= '0;
      tickQ <= 1'b0;
    end else if (strb.load) begin
      cnt   <= reloadVal;
      rateQ <= 1'b0;
      pre   <= '0;
      tickQ <= 1'b0;
    end else if (cnt == '0) begin
      cnt   <= reloadVal;
      rateQ <= ~rateQ;
      tickQ <= 1'b0;
      if (!rateQ) begin
        if (pre == preLimit(modeQ)) begin
          pre   <= '0;
          tickQ <= 1'b1;
        end else begin
          pre <= pre + PRE_W'(1);
        end
      end
    end else begin
      cnt   <= cnt - CNT_W'(1);
      tickQ <= 1'b0;
    end
  end

  assign rateClk = rateQ;
  assign tick    = tickQ;

endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import brg_pkg::*;
#(
  parameter int BYTE_W   = BRG_BYTE_W,
  parameter int PRE_W    = BRG_PRE_W,
  parameter int MODE_LSB = BRG_MODE_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              brgEnable,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [BYTE_W-1:0] wrData,
  output logic              rateClk,
  output logic              tick
);

  brgStrb_t strb;

  brg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .brgEnable(brgEnable),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .strb     (strb)
  );

  brg_datapath #(
    .BYTE_W  (BYTE_W),
    .PRE_W   (PRE_W),
    .MODE_LSB(MODE_LSB)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .rateClk(rateClk),
    .tick   (tick)
  );

endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk (
  input logic clk,
  input logic rstN,
  input logic brgEnable,
  input logic wrEn,
  input logic loadStb,
  input logic rateClk,
  input logic tick
);

  assert_tick_on_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> (rateClk && !$past(rateClk)));

  assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    !brgEnable |=> (!tick && !rateClk));

  assert_restart_after_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> ##1 (!rateClk && !tick));

  assert_min_half_period_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rateClk) && !loadStb) |=> rateClk);

endmodule

bind baud_gen baud_gen_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .brgEnable(brgEnable),
  .wrEn     (wrEn),
  .loadStb  (strb.load),
  .rateClk  (rateClk),
  .tick     (tick)
);

// File: tb/tb_baud_gen.sv
module tb_baud_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       brgEnable = 1'b1;
  logic       wrEn = 1'b0;
  logic [1:0] wrSel = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       rateClk, tick;

  int nRun = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  baud_gen dut (
    .clk(clk), .rstN(rstN), .brgEnable(brgEnable), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .rateClk(rateClk), .tick(tick)
  );

  // {time constant, transmit control byte, expected tick period}
  localparam int NVEC = 7;
  localparam logic [35:0] VECS [NVEC] = '{
    {16'h0000, 8'h00, 12'd4},
    {16'h0003, 8'h00, 12'd10},
    {16'h0001, 8'h40, 12'd96},
    {16'h0000, 8'h80, 12'd128},
    {16'h0002, 8'hC0, 12'd512},
    {16'h0100, 8'h00, 12'd516},
    {16'h0005, 8'h7F, 12'd224}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // offset 1: counting from a write capture edge; 0: from enable
  task automatic measure(input int tc, input int per, input int offset, input string tag);
    int n = 0;
    int rise = -1;
    int tk = -1;
    while (tk < 0 && n < 5000) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (n == 1 && offset == 1)
        check(!rateClk && !tick, {tag, " R5 restart low"}, int'(rateClk), 0);
      if (rise < 0 && rateClk) rise = n;
      if (tick) tk = n;
    end
    check(rise == offset + tc + 2, {tag, " R2 first rise"}, rise, offset + tc + 2);
    check(tk == offset + per - (tc + 2), {tag, " R5/R6 first tick"}, tk, offset + per - (tc + 2));
    n = 0;
    do begin
      @(posedge clk); @(negedge clk);
      n++;
    end while (!tick && n < 5000);
    check(n == per, {tag, " R3 tick period"}, n, per);
  endtask

  initial begin
    #(4 * 150000);
    nFail++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!tick && !rateClk, "R1 reset outputs", int'(tick) + int'(rateClk), 0);
    rstN = 1'b1;
    measure(0, 4, 0, "R1 defaults");

    for (int i = 0; i < NVEC; i++) begin
      int tc, per;
      tc  = int'(VECS[i][35:20]);
      per = int'(VECS[i][11:0]);
      wr(brg_pkg::SEL_TC_LO, VECS[i][27:20]);
      wr(brg_pkg::SEL_TC_HI, VECS[i][35:28]);
      wr(brg_pkg::SEL_TXCTL, VECS[i][19:12]);
      measure(tc, per, 1, $sformatf("vec%0d R3", i));
    end

    // R7: receive control write mid-count restarts, rate unchanged
    wr(brg_pkg::SEL_TC_LO, 8'd3);
    wr(brg_pkg::SEL_TC_HI, 8'd0);
    wr(brg_pkg::SEL_TXCTL, 8'h00);
    repeat (3) @(negedge clk);
    wr(brg_pkg::SEL_RXCTL, 8'hFF);
    measure(3, 10, 1, "R7 rx control");

    // R6: disabled generator stays quiet
    @(negedge clk);
    brgEnable = 1'b0;
    @(posedge clk); @(negedge clk);
    begin
      int seen = 0;
      for (int k = 0; k < 600; k++) begin
        @(posedge clk); @(negedge clk);
        if (tick || rateClk) seen++;
      end
      check(seen == 0, "R6 quiet while disabled", seen, 0);
    end
    brgEnable = 1'b1;
    measure(3, 10, 0, "R6 enable restart");

    // R3 with x16 after enable restart path
    @(negedge clk);
    brgEnable = 1'b0;
    wr(brg_pkg::SEL_TXCTL, 8'h40);
    @(negedge clk);
    brgEnable = 1'b1;
    measure(3, 160, 0, "R6 x16 enable");

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule